// File: doc/BRIEF.md
# Byte-Wide Serial Master with Fault Interrupts

This block moves one byte at a time over a three-wire synchronous serial link, acting as the clocking side. A host writes a control register to pick the idle level of the serial clock, the clock edge on which data is captured, and a clock divisor. It then writes a byte to the data register. The block shifts that byte out most-significant bit first on `sck`/`mosi` and gathers the byte arriving on `miso` into a receive buffer that the host reads back from the same register address.

Four events are recorded as sticky status flags: a finished transfer, a data write that arrives while a byte is still moving, a slave-select input pulled low while the block is mastering the link, and a received byte that lands on top of one the host has not yet read. Each flag has its own enable bit. The single interrupt output is asserted whenever an enabled flag is set. Flags are cleared by writing ones to them.

The register interface is a plain single-cycle bus. `reg_sel` picks one of four registers. Reads are combinational. Writes take effect at the next rising clock edge.

Top module: `spi_fault_master`

## Requirements
- R1: After reset the control, status and enable registers read 0x00, `sck` and `mosi` are low, and `irq` is low.
- R2: Control register (select 0) layout: bit 0 master enable, bit 1 clock polarity, bit 2 clock phase, bit 3 slave-select detection enable, bits 7:4 divisor D. While no transfer runs, `sck` equals the polarity bit.
- R3: A data write (select 1) with master enable set and no transfer running starts a transfer. The transfer makes 16 `sck` edges spaced D+1 clocks apart, the first edge coming D+1 clocks after the write, and sends the byte MSB first on `mosi`.
- R4: With phase 0, the first bit is on `mosi` from the clock after the write. `miso` is captured on edges 1, 3, …, 15 (the leading edges), and `mosi` advances on the edges between them.
- R5: With phase 1, `miso` is captured on edges 2, 4, …, 16 (the trailing edges), and `mosi` advances on the leading edges from the second one onward.
- R6: Polarity, phase and divisor are taken when a transfer starts. Control writes during a transfer affect only later transfers.
- R7: One clock after the final `sck` edge, the received byte appears in the receive buffer (read at select 1) and status bit 7 sets.
- R8: A data write while a transfer runs sets status bit 6 and discards the written byte. The running transfer is unaffected.
- R9: `ss_n` passes through a two-stage synchronizer. Once the synchronized value is low while master enable and detection enable are both 1, status bit 5 sets, the running transfer stops with `sck` back at idle, and master enable clears. With detection enable at 0, `ss_n` has no effect.
- R10: Status bit 4 sets when a received byte is loaded while the previous one is still unread. A read of select 1 marks the buffer as read.
- R11: Writing the status register (select 2) clears each flag whose bit is written as 1 and leaves bits written as 0 unchanged. A set event in the same clock takes priority over the clear.
- R12: The enable register (select 3) uses bits 7:4 with the same meaning as the status bits. `irq` is high exactly when some status bit and its enable bit are both 1. Bits 3:0 of both registers read 0.
- R13: A data write while master enable is 0 and no transfer runs does nothing. No `sck` activity follows and no status bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 control, 1 data, 2 status, 3 enable |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (marks the receive buffer as read when select is 1) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | input | 1 | Active-low slave-select sense input |
| irq | output | 1 | Combined interrupt |

## Verification
The bench checks the capture edge under both phase settings, with a pseudo-random `miso` stream. A design that samples on the wrong edge reads back a byte shifted by one bit, and the cycle-by-cycle comparison shows the mismatch. It rewrites the control register in the middle of a transfer. A design that does not hold the settings taken at the start changes the `sck` spacing or the sampling edge in mid-byte. It also covers a data write during a busy transfer, a second completion with the buffer still unread, and `ss_n` pulled low both with detection disabled and in the middle of a slow transfer. A wrong design there either loses the collision or overrun flag, or keeps clocking after a fault, or leaves master enable set. Finally, it writes zeros and partial masks to the status register. A design that clears on any write, or lets the clear win over a same-cycle set, shows up as a wrong status read.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;
  localparam int BYTE_W = 8;
  localparam int FLAG_N = 4;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;
  localparam logic [1:0] SEL_IEN  = 2'd3;

  localparam int C_MEN = 0;
  localparam int C_POL = 1;
  localparam int C_PHA = 2;
  localparam int C_SSD = 3;
  localparam int C_DIV = 4;

  typedef struct packed {
    logic done;
    logic wcol;
    logic modf;
    logic ovr;
  } flags_t;
endpackage

// File: rtl/spi_fm_sync.sv
module spi_fm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= {STAGES{RST_VAL}};
    else        ff_q <= {ff_q[STAGES-2:0], d};
  end

  assign q = ff_q[STAGES-1];
endmodule

// File: rtl/spi_fm_engine.sv
module spi_fm_engine #(
  parameter int BYTE_W = 8,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              cpol,
  input  logic              cpha,
  input  logic [DIV_W-1:0]  div,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              miso,
  output logic              busy,
  output logic              sck,
  output logic              mosi,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte
);
  localparam int EDGES = 2 * BYTE_W;
  localparam int EW    = $clog2(EDGES);

  logic              busy_q, busy_d;
  logic              sck_q, sck_d;
  logic              pha_q, pha_d;
  logic              done_q, done_d;
  logic [DIV_W-1:0]  cnt_q, cnt_d, div_q, div_d;
  logic [EW-1:0]     edge_q, edge_d;
  logic [BYTE_W-1:0] tx_q, tx_d, rx_q, rx_d;
  logic              tick, last, samp;

  assign tick = busy_q && (cnt_q == div_q);
  assign last = (edge_q == EW'(EDGES - 1));
  assign samp = (edge_q[0] == pha_q);

  always_comb begin
    busy_d = busy_q;
    sck_d  = sck_q;
    pha_d  = pha_q;
    cnt_d  = cnt_q;
    div_d  = div_q;
    edge_d = edge_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    if (abort) begin
      busy_d = 1'b0;
    end else if (start && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      edge_d = '0;
      tx_d   = tx_byte;
      pha_d  = cpha;
      div_d  = div;
      sck_d  = cpol;
    end else if (busy_q) begin
      if (tick) begin
        cnt_d  = '0;
        sck_d  = ~sck_q;
        edge_d = edge_q + EW'(1);
        if (samp)
          rx_d = {rx_q[BYTE_W-2:0], miso};
        else if (!(pha_q && edge_q == '0))
          tx_d = {tx_q[BYTE_W-2:0], 1'b0};
        if (last) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end
      end else begin
        cnt_d = cnt_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      pha_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      div_q  <= '0;
      edge_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sck_q  <= sck_d;
      pha_q  <= pha_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      div_q  <= div_d;
      edge_q <= edge_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign busy    = busy_q;
  assign sck     = busy_q ? sck_q : cpol;
  assign mosi    = busy_q & tx_q[BYTE_W-1];
  assign done    = done_q;
  assign rx_byte = rx_q;
endmodule

// File: rtl/spi_fm_flags.sv
module spi_fm_flags
  import spi_fm_pkg::*;
#(
  parameter int N = FLAG_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_vec,
  input  logic         clr_wr,
  input  logic         en_wr,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] status,
  output logic [N-1:0] enables,
  output logic         irq
);
  logic [N-1:0] st_q, st_d, en_q, en_d;

  always_comb begin
    st_d = st_q;
    if (clr_wr) st_d = st_q & ~wbits;
    st_d = st_d | set_vec;
    en_d = en_wr ? wbits : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
      en_q <= '0;
    end else begin
      st_q <= st_d;
      en_q <= en_d;
    end
  end

  assign status  = st_q;
  assign enables = en_q;
  assign irq     = |(st_q & en_q);
endmodule

// File: rtl/spi_fault_master.sv
module spi_fault_master
  import spi_fm_pkg::*;
#(
  parameter int DIV_W    = BYTE_W - C_DIV,
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              sck,
  output logic              mosi,
  input  logic              miso,
  input  logic              ss_n,
  output logic              irq
);
  localparam int PAD = BYTE_W - FLAG_N;

  logic [BYTE_W-1:0] ctrl_q, ctrl_d;
  logic [BYTE_W-1:0] rxbuf_q, rxbuf_d;
  logic              rx_full_q, rx_full_d;
  logic              ss_sync;
  logic              modf_evt, data_wr, data_rd, start, wcol_set, ovr_set;
  logic              eng_busy, eng_done;
  logic [BYTE_W-1:0] eng_rx;
  logic [FLAG_N-1:0] st_flags, ien_q;
  flags_t            set_f;

  spi_fm_sync #(.STAGES(SYNC_LEN), .RST_VAL(1'b1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ss_n), .q(ss_sync)
  );

  assign modf_evt = ctrl_q[C_MEN] & ctrl_q[C_SSD] & ~ss_sync;
  assign data_wr  = reg_wr && (reg_sel == SEL_DATA);
  assign data_rd  = reg_rd && (reg_sel == SEL_DATA);
  assign start    = data_wr & ~eng_busy & ctrl_q[C_MEN] & ~modf_evt;
  assign wcol_set = data_wr & eng_busy;
  assign ovr_set  = eng_done & rx_full_q & ~data_rd;

  spi_fm_engine #(.BYTE_W(BYTE_W), .DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(modf_evt),
    .cpol(ctrl_q[C_POL]), .cpha(ctrl_q[C_PHA]),
    .div(ctrl_q[C_DIV +: DIV_W]), .tx_byte(reg_wdata), .miso(miso),
    .busy(eng_busy), .sck(sck), .mosi(mosi), .done(eng_done), .rx_byte(eng_rx)
  );

  always_comb begin
    set_f.done = eng_done;
    set_f.wcol = wcol_set;
    set_f.modf = modf_evt;
    set_f.ovr  = ovr_set;
  end

  spi_fm_flags #(.N(FLAG_N)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_f),
    .clr_wr(reg_wr && (reg_sel == SEL_STAT)),
    .en_wr(reg_wr && (reg_sel == SEL_IEN)),
    .wbits(reg_wdata[BYTE_W-1:PAD]),
    .status(st_flags), .enables(ien_q), .irq(irq)
  );

  always_comb begin
    ctrl_d    = ctrl_q;
    rxbuf_d   = rxbuf_q;
    rx_full_d = rx_full_q;
    if (reg_wr && (reg_sel == SEL_CTRL)) ctrl_d = reg_wdata;
    if (modf_evt) ctrl_d[C_MEN] = 1'b0;
    if (eng_done) begin
      rxbuf_d   = eng_rx;
      rx_full_d = 1'b1;
    end else if (data_rd) begin
      rx_full_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      rxbuf_q   <= '0;
      rx_full_q <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_d;
      rxbuf_q   <= rxbuf_d;
      rx_full_q <= rx_full_d;
    end
  end

  always_comb begin
    case (reg_sel)
      SEL_CTRL: reg_rdata = ctrl_q;
      SEL_DATA: reg_rdata = rxbuf_q;
      SEL_STAT: reg_rdata = {st_flags, {PAD{1'b0}}};
      default:  reg_rdata = {ien_q, {PAD{1'b0}}};
    endcase
  end
endmodule

// File: rtl/spi_fault_master_chk.sv
module spi_fault_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] reg_sel,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic       sck,
  input logic       busy,
  input logic       done,
  input logic       men,
  input logic       ssden,
  input logic       cpol,
  input logic       ss_sync,
  input logic [3:0] status,
  input logic       rx_full
);
  a_r9_modf_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (men && ssden && !ss_sync) |=> (!men && !busy && status[1]));

  a_r8_wcol_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd1 && busy) |=> status[2]);

  a_r7_done_loads: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (status[3] && rx_full));

  a_r10_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rx_full && !(reg_rd && reg_sel == 2'd1)) |=> status[0]);

  a_r13_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd1 && !men && !busy) |=> !busy);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && $stable(cpol)) |-> $stable(sck));
endmodule

bind spi_fault_master spi_fault_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .sck(sck), .busy(eng_busy), .done(eng_done), .men(ctrl_q[0]), .ssden(ctrl_q[3]),
  .cpol(ctrl_q[1]), .ss_sync(ss_sync), .status(st_flags), .rx_full(rx_full_q)
);

// File: tb/spi_fault_master_tb.sv
module spi_fault_master_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel_i = 2'd0;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wd = 8'h00;
  logic [7:0] reg_rdata;
  logic       sck, mosi, irq;
  logic       miso_i = 1'b0, ss_n_i = 1'b1;
  logic [7:0] lfsr = 8'h5B;

  int    vecs = 0, fails = 0;
  bit    finished = 0;
  string tag = "R1";

  always #5 clk = ~clk;

  spi_fault_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(sel_i), .reg_wr(wr_i), .reg_rd(rd_i),
    .reg_wdata(wd), .reg_rdata(reg_rdata), .sck(sck), .mosi(mosi),
    .miso(miso_i), .ss_n(ss_n_i), .irq(irq)
  );

  always @(negedge clk) begin
    lfsr   <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    miso_i <= lfsr[7];
  end

  // behavioural reference model
  bit       m_men, m_cpol, m_cpha, m_ssd, m_busy, m_pha, m_sck, m_done, m_full, s1, s2;
  int       m_div, m_divl, m_t, m_shifts;
  logic [7:0] m_txo, m_rx, m_rxbuf;
  logic [3:0] m_st, m_en;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_men = 0; m_cpol = 0; m_cpha = 0; m_ssd = 0; m_div = 0;
      m_busy = 0; m_pha = 0; m_sck = 0; m_done = 0; m_full = 0;
      s1 = 1; s2 = 1; m_divl = 0; m_t = 0; m_shifts = 0;
      m_txo = 0; m_rx = 0; m_rxbuf = 0; m_st = 0; m_en = 0;
    end else begin
      bit evt, dwr, drd, ovr, wcol, strt, donein;
      evt    = m_men && m_ssd && !s2;
      dwr    = wr_i && sel_i == 2'd1;
      drd    = rd_i && sel_i == 2'd1;
      ovr    = m_done && m_full && !drd;
      wcol   = dwr && m_busy;
      strt   = dwr && !m_busy && m_men && !evt;
      donein = m_done;
      if (m_done) begin m_rxbuf = m_rx; m_full = 1; end
      else if (drd) m_full = 0;
      m_done = 0;
      if (m_busy) begin
        if (evt) m_busy = 0;
        else begin
          if ((m_t % (m_divl + 1)) == m_divl) begin
            int e;
            e = m_t / (m_divl + 1);
            m_sck = !m_sck;
            if ((e % 2) == int'(m_pha)) m_rx = {m_rx[6:0], miso_i};
            else if (!(m_pha && e == 0) && e != 15) m_shifts++;
            if (e == 15) begin m_busy = 0; m_done = 1; end
          end
          m_t++;
        end
      end else if (strt) begin
        m_busy = 1; m_t = 0; m_txo = wd; m_shifts = 0;
        m_pha = m_cpha; m_divl = m_div; m_sck = m_cpol;
      end
      if (wr_i && sel_i == 2'd0) begin
        m_men = wd[0]; m_cpol = wd[1]; m_cpha = wd[2]; m_ssd = wd[3]; m_div = int'(wd[7:4]);
      end
      if (evt) m_men = 0;
      if (wr_i && sel_i == 2'd2) m_st = m_st & ~wd[7:4];
      m_st = m_st | {donein, wcol, evt, ovr};
      if (wr_i && sel_i == 2'd3) m_en = wd[7:4];
      s2 = s1; s1 = ss_n_i;
    end
  end

  task automatic chk(input string t, input logic [7:0] act, input logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!finished) begin
      logic [7:0] e_rd;
      case (sel_i)
        2'd0: e_rd = {4'(m_div), m_ssd, m_cpha, m_cpol, m_men};
        2'd1: e_rd = m_rxbuf;
        2'd2: e_rd = {m_st, 4'h0};
        default: e_rd = {m_en, 4'h0};
      endcase
      chk({tag, " sck"},   {7'd0, sck},  {7'd0, m_busy ? m_sck : m_cpol});
      chk({tag, " mosi"},  {7'd0, mosi}, {7'd0, m_busy ? m_txo[7 - m_shifts] : 1'b0});
      chk({tag, " irq"},   {7'd0, irq},  {7'd0, |(m_st & m_en)});
      chk({tag, " rdata"}, reg_rdata, e_rd);
    end
  end

  task automatic bus(input bit w, input bit r, input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); wr_i = w; rd_i = r; sel_i = s; wd = d;
    @(negedge clk); wr_i = 0; rd_i = 0;
  endtask

  task automatic expect_reg(input string t, input logic [1:0] s, input logic [7:0] exp);
    @(negedge clk); sel_i = s;
    @(posedge clk); #3;
    chk(t, reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    tag = "R1";
    expect_reg("R1 ctrl", 2'd0, 8'h00);
    expect_reg("R1 status", 2'd2, 8'h00);
    expect_reg("R1 enable", 2'd3, 8'h00);
    chk("R1 sck/mosi/irq", {5'd0, sck, mosi, irq}, 8'h00);

    tag = "R2";
    bus(1, 0, 2'd0, 8'h02);
    chk("R2 idle sck high", {7'd0, sck}, 8'h01);
    expect_reg("R2 ctrl", 2'd0, 8'h02);

    tag = "R4";
    bus(1, 0, 2'd3, 8'hF0);
    bus(1, 0, 2'd0, 8'h11);
    bus(1, 0, 2'd1, 8'hA5);
    chk("R4 first bit early", {6'd0, sck, mosi}, 8'h01);
    tag = "R3";
    idle(40);
    tag = "R7";
    expect_reg("R7 done flag", 2'd2, 8'h80);
    chk("R12 irq on done", {7'd0, irq}, 8'h01);
    bus(0, 1, 2'd1, 8'h00);

    tag = "R11";
    bus(1, 0, 2'd2, 8'h00);
    expect_reg("R11 zero write", 2'd2, 8'h80);
    bus(1, 0, 2'd2, 8'h80);
    expect_reg("R11 clear", 2'd2, 8'h00);

    tag = "R5";
    bus(1, 0, 2'd0, 8'h07);
    bus(1, 0, 2'd1, 8'h3C);
    tag = "R6";
    bus(1, 0, 2'd0, 8'h31);
    tag = "R8";
    bus(1, 0, 2'd1, 8'h55);
    idle(24);
    expect_reg("R8 collision+done", 2'd2, 8'hC0);

    tag = "R10";
    bus(1, 0, 2'd0, 8'h01);
    bus(1, 0, 2'd1, 8'h81);
    idle(20);
    expect_reg("R10 overrun", 2'd2, 8'hD0);
    tag = "R11";
    bus(1, 0, 2'd2, 8'h10);
    expect_reg("R11 partial clear", 2'd2, 8'hC0);
    bus(1, 0, 2'd2, 8'hC0);
    bus(0, 1, 2'd1, 8'h00);

    tag = "R9";
    ss_n_i = 1'b0;
    idle(5);
    expect_reg("R9 detect off status", 2'd2, 8'h00);
    expect_reg("R9 detect off ctrl", 2'd0, 8'h01);
    ss_n_i = 1'b1;
    idle(3);
    bus(1, 0, 2'd0, 8'h39);
    bus(1, 0, 2'd1, 8'h96);
    idle(10);
    ss_n_i = 1'b0;
    idle(4);
    expect_reg("R9 men cleared", 2'd0, 8'h38);
    expect_reg("R9 fault flag", 2'd2, 8'h20);
    chk("R9 sck idle mosi low", {6'd0, sck, mosi}, 8'h00);
    ss_n_i = 1'b1;
    idle(4);

    tag = "R13";
    bus(1, 0, 2'd0, 8'h30);
    bus(1, 0, 2'd1, 8'hFF);
    idle(20);
    expect_reg("R13 no transfer", 2'd2, 8'h20);
    chk("R13 mosi quiet", {7'd0, mosi}, 8'h00);

    tag = "R12";
    bus(1, 0, 2'd3, 8'h2F);
    expect_reg("R12 enable low bits", 2'd3, 8'h20);
    chk("R12 irq enabled", {7'd0, irq}, 8'h01);
    bus(1, 0, 2'd3, 8'h80);
    chk("R12 irq masked", {7'd0, irq}, 8'h00);
    bus(1, 0, 2'd2, 8'h2F);
    expect_reg("R12 status cleared", 2'd2, 8'h00);
    idle(3);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule